// File: doc/BRIEF.md
# Fixed-Latency Kernel Processing-Element Shell

This block wraps a compute kernel whose latency is fixed but not known when the block is built. Operands arrive on several 32-bit input channels. Each channel has a valid/ready handshake and its own 8-entry queue. Results leave on one or more 32-bit output channels, each buffered the same way. The kernel sits outside the shell. The shell presents one complete operand set per issue, together with an issue strobe. It then captures the kernel's result bus after the configured number of cycles, with no completion handshake from the kernel.

A small configuration port loads the kernel latency into a register. The control logic never issues an operand set unless every input queue holds data. It also needs every output queue to have room for the new result on top of all results still in flight, so a stalled consumer can never make a result get lost. The latency can only change while nothing is in flight.

A new write takes priority over an issue in the same cycle. The held-back operand set leaves one cycle later and runs under the new latency.

Top module: `kernel_pe_shell`

## Requirements
- R1: After reset all queues are empty and every `inReady` is 1. Every `outValid` and `kernIssue` is 0. The latency register holds `RESET_LAT` (default 3).
- R2: Each input queue stores up to `Q_DEPTH` (8) words in arrival order. `inReady` of a channel is 0 exactly while its queue holds 8 words, and a word is taken only when valid and ready are both 1.
- R3: `kernIssue` is 1 for one cycle when every input queue is non-empty and issue is not otherwise blocked. In that cycle `kernOperands[32*i +: 32]` is the oldest word of input channel i, and one word leaves each input queue.
- R4: A configuration write with a value from 1 to `MAX_LAT` (16) loads the latency register. A write of 0 or of a value above 16 is ignored.
- R5: A set issued in cycle t with latency L has its `kernResult` sampled in cycle t+L. Channel j's 32-bit slice is pushed into output queue j, and `outValid` can rise in cycle t+L+1.
- R6: No set is issued while, for any output queue, its stored words plus the sets in flight are 8 or more.
- R7: A configuration write made while any set is in flight is ignored.
- R8: A configuration write that is accepted blocks issue in its own cycle. An operand set ready in that cycle issues in the next one and uses the new latency.
- R9: Each output queue presents its oldest word with `outValid`=1 while non-empty and drops it when `outReady` is 1. Results appear in issue order.
- R10: With all inputs valid, outputs always ready and room available, one set issues every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inData | input | NUM_IN*32 | Input channel words, channel i at bits 32*i |
| inValid | input | NUM_IN | Per-channel input valid |
| inReady | output | NUM_IN | Per-channel input ready (queue not full) |
| outData | output | NUM_OUT*32 | Oldest word of each output queue |
| outValid | output | NUM_OUT | Output queue non-empty |
| outReady | input | NUM_OUT | Consumer takes the presented word |
| cfgWrite | input | 1 | Latency write strobe |
| cfgLatency | input | clog2(MAX_LAT+1) | Latency value to load |
| kernIssue | output | 1 | Operand set presented to the kernel this cycle |
| kernOperands | output | NUM_IN*32 | Operand set for the kernel |
| kernResult | input | NUM_OUT*32 | Kernel result bus, sampled at the latency count |

## Verification
A configuration write and an operand issue can fall in the same cycle. Two other pairs can also coincide: a result capture with an output pop, and an input push with an issue pop on the same queue.

The write/issue collision is provoked as follows. Input words are pushed in one cycle while the block is idle, and an in-range latency write follows in the next cycle. The bench then expects `kernIssue` low in the write cycle, the issue one cycle later, and the result captured at the new latency.

A cycle-accurate behavioural model with its own queues and in-flight list is compared with every output on every clock. The bench's kernel model emits marker words outside issue cycles, so a capture in the wrong cycle shows up as a data mismatch.

// File: rtl/kernel_pe_pkg.sv
`timescale 1ns/1ps
package kernel_pe_pkg;
  localparam int CHAN_W = 32;

  typedef struct packed {
    logic issue;    // pop one operand set and present it to the kernel
    logic capture;  // push kernel result into the output queues
  } peStrobe_t;
endpackage

// File: rtl/pe_fifo.sv
`timescale 1ns/1ps
module pe_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic [WIDTH-1:0]           wrData,
  input  logic                       rdEn,
  output logic [WIDTH-1:0]           rdData,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (wrEn) wrPtr <= nextPtr(wrPtr);
      if (rdEn) rdPtr <= nextPtr(rdPtr);
      level <= level + CNT_W'(wrEn) - CNT_W'(rdEn);
    end
  end

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrPtr] <= wrData;
  end

  assign rdData = mem[rdPtr];

  // R2: a write never lands on a full queue
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> (level != CNT_W'(DEPTH)));

  // R3: a read never hits an empty queue
  a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |-> (level != '0));
endmodule

// File: rtl/pe_ctrl.sv
`timescale 1ns/1ps
module pe_ctrl
  import kernel_pe_pkg::*;
#(
  parameter int NUM_IN    = 4,
  parameter int NUM_OUT   = 1,
  parameter int Q_DEPTH   = 8,
  parameter int MAX_LAT   = 16,
  parameter int RESET_LAT = 3
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic [NUM_IN-1:0]                      inHasData,
  input  logic [NUM_OUT*$clog2(Q_DEPTH+1)-1:0]   outLevels,
  input  logic                                   cfgWrite,
  input  logic [$clog2(MAX_LAT+1)-1:0]           cfgLatency,
  output peStrobe_t                              strb
);
  localparam int CNT_W = $clog2(Q_DEPTH + 1);
  localparam int LAT_W = $clog2(MAX_LAT + 1);
  localparam int SUM_W = CNT_W + LAT_W + 1;

  logic [LAT_W-1:0]   latReg;
  logic [LAT_W-1:0]   inFlight;
  logic [MAX_LAT-1:0] tagPipe;
  logic [MAX_LAT-1:0] hitMask;
  logic roomOk;
  logic cfgInRange;
  logic latLoad;
  logic issueGo;
  logic captureGo;

  // room for one more result in every output queue
  always_comb begin
    roomOk = 1'b1;
    for (int j = 0; j < NUM_OUT; j++) begin
      if (SUM_W'(outLevels[j*CNT_W +: CNT_W]) + SUM_W'(inFlight) >= SUM_W'(Q_DEPTH))
        roomOk = 1'b0;
    end
  end

  // selects the tag stage matching the configured latency
  always_comb begin
    for (int k = 0; k < MAX_LAT; k++) begin
      hitMask[k] = (latReg == LAT_W'(k + 1));
    end
  end

  assign cfgInRange = (cfgLatency != '0) && (cfgLatency <= LAT_W'(MAX_LAT));
  assign latLoad    = cfgWrite && (inFlight == '0) && cfgInRange;
  assign issueGo    = (&inHasData) && roomOk && !latLoad;
  assign captureGo  = |(tagPipe & hitMask);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latReg   <= LAT_W'(RESET_LAT);
      tagPipe  <= '0;
      inFlight <= '0;
    end else begin
      if (latLoad) begin
        latReg  <= cfgLatency;
        tagPipe <= '0;
      end else begin
        tagPipe <= {tagPipe[MAX_LAT-2:0], issueGo};
      end
      inFlight <= inFlight + LAT_W'(issueGo) - LAT_W'(captureGo);
    end
  end

  assign strb = '{issue: issueGo, capture: captureGo};

  // R5: every capture belongs to an issued set
  a_r5_capture_has_owner: assert property (@(posedge clk) disable iff (!rstN)
    captureGo |-> (inFlight != '0));

  // R7: latency frozen while sets are in flight
  a_r7_latency_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (inFlight != '0) |=> $stable(latReg));

  // R4: latency always inside the legal range
  a_r4_latency_range: assert property (@(posedge clk) disable iff (!rstN)
    (latReg != '0) && (latReg <= LAT_W'(MAX_LAT)));

  // R6: in-flight count never exceeds queue capacity
  a_r6_inflight_bound: assert property (@(posedge clk) disable iff (!rstN)
    SUM_W'(inFlight) <= SUM_W'(Q_DEPTH));
endmodule

// File: rtl/pe_datapath.sv
`timescale 1ns/1ps
module pe_datapath
  import kernel_pe_pkg::*;
#(
  parameter int NUM_IN  = 4,
  parameter int NUM_OUT = 1,
  parameter int Q_DEPTH = 8
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic [NUM_IN*CHAN_W-1:0]             inData,
  input  logic [NUM_IN-1:0]                    inValid,
  output logic [NUM_IN-1:0]                    inReady,
  output logic [NUM_OUT*CHAN_W-1:0]            outData,
  output logic [NUM_OUT-1:0]                   outValid,
  input  logic [NUM_OUT-1:0]                   outReady,
  input  peStrobe_t                            strb,
  output logic [NUM_IN*CHAN_W-1:0]             kernOperands,
  input  logic [NUM_OUT*CHAN_W-1:0]            kernResult,
  output logic [NUM_IN-1:0]                    inHasData,
  output logic [NUM_OUT*$clog2(Q_DEPTH+1)-1:0] outLevels
);
  localparam int CNT_W = $clog2(Q_DEPTH + 1);

  for (genvar i = 0; i < NUM_IN; i++) begin : g_inQ
    logic [CNT_W-1:0] lvl;
    logic             push;
    assign inReady[i]   = (lvl != CNT_W'(Q_DEPTH));
    assign inHasData[i] = (lvl != '0);
    assign push         = inValid[i] & inReady[i];
    pe_fifo #(.WIDTH(CHAN_W), .DEPTH(Q_DEPTH)) u_q (
      .clk    (clk),
      .rstN   (rstN),
      .wrEn   (push),
      .wrData (inData[i*CHAN_W +: CHAN_W]),
      .rdEn   (strb.issue),
      .rdData (kernOperands[i*CHAN_W +: CHAN_W]),
      .level  (lvl)
    );
  end

  for (genvar j = 0; j < NUM_OUT; j++) begin : g_outQ
    logic [CNT_W-1:0] lvl;
    logic             pop;
    assign outValid[j]                  = (lvl != '0);
    assign pop                          = outValid[j] & outReady[j];
    assign outLevels[j*CNT_W +: CNT_W]  = lvl;
    pe_fifo #(.WIDTH(CHAN_W), .DEPTH(Q_DEPTH)) u_q (
      .clk    (clk),
      .rstN   (rstN),
      .wrEn   (strb.capture),
      .wrData (kernResult[j*CHAN_W +: CHAN_W]),
      .rdEn   (pop),
      .rdData (outData[j*CHAN_W +: CHAN_W]),
      .level  (lvl)
    );
  end

  // R3: an issue only happens with a word waiting in every input queue
  a_r3_issue_needs_all: assert property (@(posedge clk) disable iff (!rstN)
    strb.issue |-> (&inHasData));
endmodule

// File: rtl/kernel_pe_shell.sv
`timescale 1ns/1ps
module kernel_pe_shell
  import kernel_pe_pkg::*;
#(
  parameter int NUM_IN    = 4,
  parameter int NUM_OUT   = 1,
  parameter int Q_DEPTH   = 8,
  parameter int MAX_LAT   = 16,
  parameter int RESET_LAT = 3
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_IN*32-1:0]           inData,
  input  logic [NUM_IN-1:0]              inValid,
  output logic [NUM_IN-1:0]              inReady,
  output logic [NUM_OUT*32-1:0]          outData,
  output logic [NUM_OUT-1:0]             outValid,
  input  logic [NUM_OUT-1:0]             outReady,
  input  logic                           cfgWrite,
  input  logic [$clog2(MAX_LAT+1)-1:0]   cfgLatency,
  output logic                           kernIssue,
  output logic [NUM_IN*32-1:0]           kernOperands,
  input  logic [NUM_OUT*32-1:0]          kernResult
);
  localparam int CNT_W = $clog2(Q_DEPTH + 1);

  peStrobe_t                  strb;
  logic [NUM_IN-1:0]          inHasData;
  logic [NUM_OUT*CNT_W-1:0]   outLevels;

  pe_ctrl #(
    .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .Q_DEPTH(Q_DEPTH),
    .MAX_LAT(MAX_LAT), .RESET_LAT(RESET_LAT)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .inHasData  (inHasData),
    .outLevels  (outLevels),
    .cfgWrite   (cfgWrite),
    .cfgLatency (cfgLatency),
    .strb       (strb)
  );

  pe_datapath #(
    .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .Q_DEPTH(Q_DEPTH)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .inData       (inData),
    .inValid      (inValid),
    .inReady      (inReady),
    .outData      (outData),
    .outValid     (outValid),
    .outReady     (outReady),
    .strb         (strb),
    .kernOperands (kernOperands),
    .kernResult   (kernResult),
    .inHasData    (inHasData),
    .outLevels    (outLevels)
  );

  assign kernIssue = strb.issue;
endmodule

// File: tb/kernel_pe_shell_test.sv
`timescale 1ns/1ps
module kernel_pe_shell_test;
  localparam int NI = 4;
  localparam int QD = 8;
  localparam int ML = 16;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [NI*32-1:0] inData = '0;
  logic [NI-1:0]   inValid = '0;
  logic [NI-1:0]   inReady;
  logic [31:0]     outData;
  logic [0:0]      outValid;
  logic [0:0]      outReady = '0;
  logic            cfgWrite = 1'b0;
  logic [4:0]      cfgLatency = '0;
  logic            kernIssue;
  logic [NI*32-1:0] kernOperands;
  logic [31:0]     kernResult;

  kernel_pe_shell uut (
    .clk(clk), .rstN(rstN), .inData(inData), .inValid(inValid), .inReady(inReady),
    .outData(outData), .outValid(outValid), .outReady(outReady),
    .cfgWrite(cfgWrite), .cfgLatency(cfgLatency), .kernIssue(kernIssue),
    .kernOperands(kernOperands), .kernResult(kernResult)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  string phaseTag = "R1 reset";

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s [%s] %s actual=%h expected=%h", rq, phaseTag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] kfun(input logic [NI*32-1:0] ops);
    logic [31:0] s = 32'h0;
    for (int i = 0; i < NI; i++) s = s + ops[i*32 +: 32];
    return s ^ 32'h5A5A_0F0F;
  endfunction

  // bench kernel: fixed-latency pipeline, marker words outside issue cycles
  int          modelLat = 3;
  logic [31:0] kstage [ML];
  logic [15:0] gcnt = '0;
  always_ff @(posedge clk) begin
    gcnt <= gcnt + 1'b1;
    kstage[0] <= kernIssue ? kfun(kernOperands) : {16'hBAD0, gcnt};
    for (int k = 1; k < ML; k++) kstage[k] <= kstage[k-1];
  end
  assign kernResult = kstage[modelLat-1];

  // reference model state
  logic [31:0] inQ [NI][$];
  logic [31:0] outQ [$];
  int          flCycle [$];
  logic [31:0] flVal [$];
  int          cyc = 0;
  int          seqIn [NI];
  logic [31:0] rng = 32'h1234_5678;
  int          validMode = 0;
  int          readyMode = 0;
  bit          cfgPending = 0;
  logic [4:0]  cfgVal = '0;
  bit          running = 0;
  int          obsIssues = 0;
  bit          r8Seen = 0;
  bit          r8Obs = 0;

  always begin
    @(negedge clk);
    if (running) begin
      logic [NI-1:0] expReady;
      logic [NI*32-1:0] expOps;
      bit allData, room, latW, expIssue, capture, cfgOk;
      string issTag;
      rng = rng ^ (rng << 13);
      rng = rng ^ (rng >> 17);
      rng = rng ^ (rng << 5);
      for (int i = 0; i < NI; i++) begin
        case (validMode)
          1: inValid[i] = 1'b1;
          2: inValid[i] = rng[i];
          3: inValid[i] = (i != 0);
          default: inValid[i] = 1'b0;
        endcase
        inData[i*32 +: 32] = {i[7:0], 24'(seqIn[i])};
      end
      outReady[0] = (readyMode == 1) || (readyMode == 2 && rng[9]);
      cfgWrite   = cfgPending;
      cfgLatency = cfgVal;
      cfgPending = 0;
      #2;
      allData = 1;
      for (int i = 0; i < NI; i++) begin
        expReady[i] = (inQ[i].size() < QD);
        if (inQ[i].size() == 0) allData = 0;
        else expOps[i*32 +: 32] = inQ[i][0];
      end
      room     = (outQ.size() + flCycle.size()) < QD;
      cfgOk    = cfgWrite && cfgLatency >= 1 && cfgLatency <= ML;
      latW     = cfgOk && flCycle.size() == 0;
      expIssue = allData && room && !latW;
      issTag   = !room ? "R6" : (latW ? "R8" : "R3");
      chk(inReady === expReady, "R2", "inReady", 32'(inReady), 32'(expReady));
      chk(outValid[0] === (outQ.size() > 0), "R9", "outValid",
          32'(outValid), 32'(outQ.size() > 0));
      if (outQ.size() > 0) chk(outData === outQ[0], "R5", "outData", outData, outQ[0]);
      chk(kernIssue === expIssue, issTag, "kernIssue", 32'(kernIssue), 32'(expIssue));
      if (expIssue)
        for (int i = 0; i < NI; i++)
          chk(kernOperands[i*32 +: 32] === expOps[i*32 +: 32], "R3", "kernOperands",
              kernOperands[i*32 +: 32], expOps[i*32 +: 32]);
      if (kernIssue === 1'b1) obsIssues++;
      if (latW && allData) begin r8Seen = 1; r8Obs = kernIssue; end
      // advance model as the clock edge will
      capture = flCycle.size() > 0 && (flCycle[0] + modelLat == cyc);
      if (outQ.size() > 0 && outReady[0]) void'(outQ.pop_front());
      for (int i = 0; i < NI; i++) begin
        if (expIssue) void'(inQ[i].pop_front());
        if (inValid[i] && expReady[i]) begin
          inQ[i].push_back(inData[i*32 +: 32]);
          seqIn[i]++;
        end
      end
      if (capture) begin
        outQ.push_back(flVal.pop_front());
        void'(flCycle.pop_front());
      end
      if (expIssue) begin
        flCycle.push_back(cyc);
        flVal.push_back(kfun(expOps));
      end
      if (latW) modelLat = int'(cfgLatency);
      cyc++;
    end
  end

  task automatic setMode(input int v, input int r);
    @(posedge clk);
    validMode = v;
    readyMode = r;
  endtask

  task automatic runCycles(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic cfgPut(input logic [4:0] v);
    @(posedge clk);
    cfgPending = 1;
    cfgVal = v;
    @(posedge clk);
  endtask

  task automatic drain();
    setMode(0, 1);
    for (int n = 0; n < 300; n++) begin
      bit idle = (outQ.size() == 0) && (flCycle.size() == 0);
      for (int i = 0; i < NI; i++) if (inQ[i].size() != 0) idle = 0;
      if (idle) break;
      @(posedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < NI; i++) seqIn[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #2;
    chk(inReady === '1, "R1", "inReady after reset", 32'(inReady), 32'hF);
    chk(outValid === 1'b0, "R1", "outValid after reset", 32'(outValid), 0);
    chk(kernIssue === 1'b0, "R1", "kernIssue after reset", 32'(kernIssue), 0);
    running = 1;

    // default latency 3 in use
    phaseTag = "R1 default latency";
    setMode(1, 1);
    runCycles(30);

    // R2: queue fill with channel 0 idle
    drain();
    phaseTag = "R2 fill";
    setMode(3, 1);
    runCycles(15);
    @(negedge clk); #3;
    chk(inReady === 4'b0001, "R2", "inReady with full queues", 32'(inReady), 32'h1);

    // R4: load latency 5, then R10 streaming
    drain();
    phaseTag = "R4 load";
    cfgPut(5'd5);
    phaseTag = "R10 streaming";
    setMode(1, 1);
    runCycles(10);
    obsIssues = 0;
    runCycles(20);
    chk(obsIssues == 20, "R10", "issues in 20 cycles", 32'(obsIssues), 32'd20);

    // R6: consumer stalls
    phaseTag = "R6 stall";
    setMode(1, 0);
    runCycles(40);
    @(negedge clk); #3;
    chk(kernIssue === 1'b0, "R6", "issue held at full", 32'(kernIssue), 0);
    chk(outValid === 1'b1, "R6", "results held", 32'(outValid), 1);

    // R7: write during flight ignored
    phaseTag = "R7 busy write";
    setMode(1, 1);
    runCycles(8);
    cfgPut(5'd2);
    runCycles(30);

    // R4: out-of-range writes ignored
    drain();
    phaseTag = "R4 range";
    cfgPut(5'd0);
    cfgPut(5'd17);
    setMode(1, 1);
    runCycles(25);

    // R8: write and issue in the same cycle
    drain();
    phaseTag = "R8 collision";
    r8Seen = 0;
    setMode(1, 1);
    @(posedge clk);
    validMode = 0;
    cfgPending = 1;
    cfgVal = 5'd2;
    runCycles(12);
    chk(r8Seen && !r8Obs, "R8", "issue deferred by write", 32'(r8Obs), 0);

    // R9: random traffic at latency 2
    phaseTag = "R9 random";
    setMode(2, 2);
    runCycles(300);

    // long latency: reservation limits in-flight sets
    drain();
    phaseTag = "R6 long latency";
    cfgPut(5'd16);
    setMode(1, 1);
    runCycles(100);
    setMode(2, 2);
    runCycles(200);

    // shortest latency
    drain();
    phaseTag = "R5 latency 1";
    cfgPut(5'd1);
    setMode(1, 1);
    runCycles(50);
    setMode(2, 2);
    runCycles(200);

    drain();
    running = 0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule